// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block drives an external 12-bit digital-to-analog converter over a write-only SPI link. A request carries a 12-bit sample code and two control flags: a fast-settling select (1 = fast, noisier; 0 = slow, quieter) and a power-down flag (1 = converter powered down; 0 = normal operation). The request is taken on a valid/ready handshake. The block packs the request into one 16-bit frame and shifts it out most significant bit first. It uses a serial clock, a data line and an active-low frame select.

The serial clock idles high and uses clock phase 0. Data changes on each rising edge, so the converter samples on the falling edge. The serial clock period is `DIV` system clocks, where `DIV` is an even parameter of at least 2. The default of 8 gives a 10 MHz serial clock from an 80 MHz system clock. The block reports busy from acceptance until it can take the next frame.

Top module: `spi_dac_tx`

## Requirements
- R1: After reset, cs_n_o = 1, sclk_o = 1, sdo_o = 0, ready_o = 1 and busy_o = 0.
- R2: A request is accepted on a clock edge where valid_i and ready_o are both 1. From the next cycle, busy_o = 1 and ready_o = 0 for 17*DIV cycles. Then ready_o = 1 and busy_o = 0.
- R3: The frame is {0, fast_i, pwr_dn_i, 0, code_i[11:0]}. Bit 15 is the first bit shifted and bit 0 the last. Bit 14 is the fast select, bit 13 is power-down, and bits 15 and 12 are always 0.
- R4: sclk_o is high whenever the block is idle. During a frame, each bit lasts DIV cycles: high for the first DIV/2 cycles, low for the last DIV/2.
- R5: While cs_n_o stays low, sdo_o changes only in a cycle where sclk_o rises.
- R6: cs_n_o goes low in the cycle after acceptance, DIV/2 cycles before the first falling serial clock edge. It stays low for 16*DIV cycles and rises together with the final rising sclk_o edge. It then stays high for at least DIV cycles.
- R7: The request fields are captured at acceptance. Later changes of code_i, fast_i or pwr_dn_i do not alter the frame in flight.
- R8: A valid_i held high while busy_o = 1 neither restarts nor extends the frame in flight. It is taken only once ready_o returns to 1.
- R9: Each frame has exactly 16 falling sclk_o edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present |
| ready_o | output | 1 | Block can accept a request |
| code_i | input | 12 | Sample code for the converter |
| fast_i | input | 1 | Fast-settling select |
| pwr_dn_i | input | 1 | Power-down request |
| busy_o | output | 1 | Frame in flight or guard interval running |
| sclk_o | output | 1 | Serial clock, idle high |
| sdo_o | output | 1 | Serial data, MSB first |
| cs_n_o | output | 1 | Frame select, active low |

## Verification
Every output comes straight from a register, so its response to an accepted request appears in the cycle after the accepting edge. At offset t from that cycle, the bench expects:
- bit t/DIV on sdo_o;
- sclk_o high when t mod DIV is below DIV/2;
- cs_n_o low until t = 16*DIV;
- ready_o back at t = 17*DIV.

Inputs are driven on the falling system clock edge and outputs are sampled there, one sample per cycle. The serially captured word and the count of falling edges are compared with the frame that the bench packs from the request fields. Between acceptance and the end of the frame, the request inputs are changed to other values, and valid_i is sometimes held high, so that R7 and R8 are exercised.

// File: rtl/spi_dac_pkg.sv
package spi_dac_pkg;
  localparam int unsigned FRAME_W  = 16;
  localparam int unsigned CODE_W   = 12;
  localparam int unsigned FAST_POS = 14;
  localparam int unsigned PD_POS   = 13;
  localparam int unsigned BITCNT_W = $clog2(FRAME_W);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} tx_state_e;

  typedef struct packed {
    logic              fast;
    logic              pwr_dn;
    logic [CODE_W-1:0] code;
  } dac_req_t;
endpackage

// File: rtl/spi_dac_pack.sv
module spi_dac_pack
  import spi_dac_pkg::*;
(
  input  dac_req_t             req_i,
  output logic [FRAME_W-1:0]   frame_o
);
  always_comb begin
    frame_o                = '0;  // reserved bits stay zero
    frame_o[CODE_W-1:0]    = req_i.code;
    frame_o[FAST_POS]      = req_i.fast;
    frame_o[PD_POS]        = req_i.pwr_dn;
  end
endmodule

// File: rtl/spi_dac_tick.sv
module spi_dac_tick #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R4: phase counter never runs past the active limit
  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (cnt_q < lim_i));
endmodule

// File: rtl/spi_dac_engine.sv
module spi_dac_engine
  import spi_dac_pkg::*;
#(
  parameter int unsigned DIV = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ready_o,
  output logic               busy_o,
  output logic               sclk_o,
  output logic               sdo_o,
  output logic               cs_n_o
);
  localparam int unsigned HALF  = DIV / 2;
  localparam int unsigned CNT_W = $clog2(DIV + 1);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_W - 1);

  tx_state_e             state_q;
  logic [FRAME_W-1:0]    shreg_q;
  logic [BITCNT_W-1:0]   bitcnt_q;
  logic                  sclk_q, cs_q;
  logic                  tick;
  logic [CNT_W-1:0]      lim;

  assign lim = (state_q == ST_GAP) ? CNT_W'(DIV) : CNT_W'(HALF);

  spi_dac_tick #(.CNT_W(CNT_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .lim_i  (lim),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      sclk_q   <= 1'b1;
      cs_q     <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          shreg_q  <= frame_i;
          bitcnt_q <= '0;
          sclk_q   <= 1'b1;
          cs_q     <= 1'b0;
          state_q  <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;  // converter samples here
          end else begin
            sclk_q <= 1'b1;
            if (bitcnt_q == LAST_BIT) begin
              cs_q    <= 1'b1;
              shreg_q <= '0;
              state_q <= ST_GAP;
            end else begin
              shreg_q  <= {shreg_q[FRAME_W-2:0], 1'b0};
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_GAP: if (tick) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign busy_o  = (state_q != ST_IDLE);
  assign sclk_o  = sclk_q;
  assign sdo_o   = shreg_q[FRAME_W-1];
  assign cs_n_o  = cs_q;

  // R2: acceptance opens a frame on the next cycle
  a_r2_accept_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> (!cs_q && busy_o));
  // R4: clock parked high whenever deselected
  a_r4_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> sclk_q);
  // R5: data moves only with a rising serial clock
  a_r5_sdo_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_q && $past(!cs_q) && !$stable(shreg_q[FRAME_W-1])) |-> $rose(sclk_q));
  // R6: select released with the clock high
  a_r6_cs_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_q) |-> sclk_q);
  // R9: select released only after the last bit
  a_r9_last_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_q) |-> ($past(bitcnt_q) == LAST_BIT));
endmodule

// File: rtl/spi_dac_tx.sv
module spi_dac_tx
  import spi_dac_pkg::*;
#(
  parameter int unsigned DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [CODE_W-1:0] code_i,
  input  logic              fast_i,
  input  logic              pwr_dn_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              cs_n_o
);
  dac_req_t           req;
  logic [FRAME_W-1:0] frame;

  assign req = '{fast: fast_i, pwr_dn: pwr_dn_i, code: code_i};

  spi_dac_pack u_pack (
    .req_i   (req),
    .frame_o (frame)
  );

  spi_dac_engine #(.DIV(DIV)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (valid_i),
    .frame_i (frame),
    .ready_o (ready_o),
    .busy_o  (busy_o),
    .sclk_o  (sclk_o),
    .sdo_o   (sdo_o),
    .cs_n_o  (cs_n_o)
  );
endmodule

// File: tb/sim_spi_dac_tx.sv
module sim_spi_dac_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int HALF       = DIV / 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] code_i = '0;
  logic        fast_i = 1'b0, pwr_dn_i = 1'b0;
  logic        ready_o, busy_o, sclk_o, sdo_o, cs_n_o;

  int  total = 0, bad = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_dac_tx #(.DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
    .code_i(code_i), .fast_i(fast_i), .pwr_dn_i(pwr_dn_i), .busy_o(busy_o),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .cs_n_o(cs_n_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [11:0] c, input logic f, input logic p,
                           input logic [11:0] nc, input logic nf, input logic np,
                           input bit hold);
    logic [15:0] exp_f, rx;
    int falls;
    logic prev_sclk, prev_sdo, prev_cs;
    exp_f = {1'b0, f, p, 1'b0, c};
    code_i = c; fast_i = f; pwr_dn_i = p; valid_i = 1'b1;
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    // R7/R8: scramble inputs, optionally keep requesting
    code_i = nc; fast_i = nf; pwr_dn_i = np; valid_i = hold;
    rx = '0; falls = 0; prev_sclk = 1'b1; prev_sdo = 1'b0; prev_cs = 1'b1;
    for (int t = 0; t <= 17*DIV; t++) begin
      if (t < 16*DIV) begin
        chk(cs_n_o == 1'b0, hold ? "R8 cs" : "R6 cs", cs_n_o, 0);
        chk(sclk_o == ((t % DIV) < HALF), "R4 sclk", sclk_o, (t % DIV) < HALF);
        chk(sdo_o == exp_f[15 - t/DIV], "R3 sdo", sdo_o, exp_f[15 - t/DIV]);
        chk(busy_o && !ready_o, "R2 busy", {busy_o, ready_o}, 2);
        if (!prev_cs && (sdo_o != prev_sdo))
          chk(!prev_sclk && sclk_o, "R5 sdo edge", {prev_sclk, sclk_o}, 1);
      end else if (t < 17*DIV) begin
        chk(cs_n_o && sclk_o, hold ? "R8 gap" : "R6 gap", {cs_n_o, sclk_o}, 3);
        chk(busy_o && !ready_o, "R2 busy", {busy_o, ready_o}, 2);
      end else begin
        chk(ready_o && !busy_o, "R2 ready", {busy_o, ready_o}, 1);
      end
      if (prev_sclk && !sclk_o) begin
        rx = {rx[14:0], sdo_o};
        falls++;
      end
      prev_sclk = sclk_o; prev_sdo = sdo_o; prev_cs = cs_n_o;
      if (t < 17*DIV) @(negedge clk);
    end
    chk(falls == 16, "R9 falls", falls, 16);
    chk(rx == exp_f, "R3/R7 word", rx, exp_f);
  endtask

  function automatic logic [11:0] code_of(input int i);
    if (i % 50 == 0) return 12'h000;
    if (i % 50 == 1) return 12'hFFF;
    return 12'((i * 389 + 5) % 4096);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] cc;
    logic        cf, cp;
    @(negedge clk);
    // R1
    chk(cs_n_o && sclk_o && !sdo_o && ready_o && !busy_o, "R1 reset",
        {cs_n_o, sclk_o, sdo_o, ready_o, busy_o}, 5'b11010);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(cs_n_o && sclk_o && ready_o, "R4 idle", {cs_n_o, sclk_o, ready_o}, 7);
    end
    cc = code_of(0); cf = 1'b0; cp = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic [11:0] nc;
      logic        nf, np;
      nc = code_of(i + 1);
      nf = ((i + 1) % 4) >= 2;
      np = ((i + 1) % 2) == 1;
      run_frame(cc, cf, cp, nc, nf, np, (i % 3) == 0);
      cc = nc; cf = nf; cp = np;
    end
    valid_i = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule